// File: doc/BRIEF.md
# Stimulus Port Trace Packet Encoder

This block turns software writes to a bank of stimulus ports into trace source packets. Each write carries a port number, an access width and up to 32 bits of data. An accepted write becomes one header byte followed by a payload of one, two or four bytes. The header encodes the port, a source flag and the payload size. The bytes go into a small byte FIFO and leave one at a time over a valid/ready byte stream toward a serial output stage.

Software polls a per-port ready vector before it writes. A write to an enabled port that does not fit in the FIFO is dropped. The block then remembers the loss and places a single overflow marker byte ahead of the next packet it accepts. The receiver can then see that data went missing. Writes produce packets only while both the global trace enable and the unit enable are high.

Top module: `trace_pkt_enc`

## Requirements
- R1: The header byte carries the port number in bits [7:3], a 0 in bit 2 (software source), and the size code in bits [1:0]: 01 for a byte, 10 for a halfword, 11 for a word. A byte write to port 0 therefore gives header 0x01.
- R2: The header is followed directly by 1, 2 or 4 payload bytes for size codes 01, 10 and 11. The payload is taken from the low end of `wr_data`, least significant byte first.
- R3: A write to a port whose bit in `port_en_mask` is 0 produces no bytes and does not raise the overflow condition.
- R4: While `trace_en` or `unit_en` is low, writes produce no bytes and no overflow condition.
- R5: `stim_ready[i]` is 1 exactly when both enables are high, port i is enabled, and the FIFO has at least 5 free bytes, or 6 when an overflow marker is pending. Otherwise it is 0.
- R6: An enabled write that does not fit is dropped and sets a pending overflow. The next accepted packet is preceded by exactly one byte 0x70, and the pending state then clears.
- R7: A write is accepted only if the whole packet, including any pending 0x70, fits in the 16-byte FIFO. Packets are never split, and the FIFO never holds more than 16 bytes.
- R8: Bytes leave in the order they were queued, one per cycle with `out_valid` and `out_ready` both high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R9: A write with size code 00 is ignored. It produces no bytes and no overflow.
- R10: After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Global trace enable |
| unit_en | input | 1 | Stimulus unit enable |
| port_en_mask | input | 32 | Per-port enable mask |
| wr_valid | input | 1 | Write strobe, one write per cycle |
| wr_port | input | 5 | Target stimulus port |
| wr_size | input | 2 | Access width code (00 none, 01 byte, 10 half, 11 word) |
| wr_data | input | 32 | Write data, low bytes used |
| stim_ready | output | 32 | Per-port can-accept status for polling |
| out_valid | output | 1 | Output byte available |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream takes the byte |

## Verification
A wrong FIFO level shows up in two places. The per-port ready bits go wrong in the same cycle. The accept or drop decision goes wrong on the next write, which changes the byte stream a few cycles later. A stuck or missed overflow flag shows as a missing or extra 0x70 in front of the first packet accepted after the loss. A pointer error shows as a wrong or reordered byte as soon as that entry reaches the head of the FIFO. The bench models the queue byte by byte and compares every cycle, so each of these faults is caught at the first byte it touches.

// File: rtl/trace_pkt_pkg.sv
package trace_pkt_pkg;
  localparam int HDR_PORT_W = 5;
  localparam int PKT_MAXB   = 8;
  localparam logic [7:0] OVF_MARK = 8'h70;

  typedef enum logic [1:0] {
    SZ_NONE = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_HALF = 2'b10,
    SZ_WORD = 2'b11
  } wsize_e;
endpackage

// File: rtl/trace_pkt_build.sv
module trace_pkt_build
  import trace_pkt_pkg::*;
#(
  parameter int PORT_W = 5
) (
  input  logic [PORT_W-1:0]     port,
  input  logic [1:0]            size,
  input  logic [31:0]           data,
  input  logic                  ovf_ins,
  output logic [PKT_MAXB*8-1:0] pkt,
  output logic [3:0]            nbytes
);
  logic [2:0]            len;
  logic [7:0]            hdr;
  logic [PKT_MAXB*8-1:0] body;

  always_comb begin
    unique case (wsize_e'(size))
      SZ_BYTE: len = 3'd1;
      SZ_HALF: len = 3'd2;
      SZ_WORD: len = 3'd4;
      default: len = 3'd0;
    endcase
    hdr  = {HDR_PORT_W'(port), 1'b0, size};
    body = '0;
    body[7:0] = hdr;
    for (int k = 0; k < 4; k++) begin
      if (3'(k) < len) body[8 + 8*k +: 8] = data[8*k +: 8];
    end
    if (ovf_ins) pkt = {body[PKT_MAXB*8-9:0], OVF_MARK};
    else         pkt = body;
    if (len == 3'd0) nbytes = 4'd0;
    else             nbytes = 4'(len) + 4'd1 + 4'(ovf_ins);
  end
endmodule

// File: rtl/trace_byte_fifo.sv
module trace_byte_fifo
  import trace_pkt_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic [3:0]            push_n,
  input  logic [PKT_MAXB*8-1:0] push_bytes,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [7:0]            out_data,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, wptr_n, rptr, rptr_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          pop;

  assign out_valid = (cnt != '0);
  assign out_data  = mem[rptr];
  assign pop       = out_valid & out_ready;
  assign level     = cnt;

  always_comb begin
    wptr_n = wptr;
    rptr_n = rptr;
    cnt_n  = cnt;
    if (push) wptr_n = wptr + AW'(push_n);
    if (pop)  rptr_n = rptr + AW'(1);
    cnt_n = cnt + (push ? CW'(push_n) : '0) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      wptr <= wptr_n;
      rptr <= rptr_n;
      cnt  <= cnt_n;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic [AW-1:0] off;
    logic          we;
    assign off = AW'(e) - wptr;
    assign we  = push && ({1'b0, off} < (AW+1)'(push_n));
    always_ff @(posedge clk) begin
      if (we) mem[e] <= push_bytes[8*off[2:0] +: 8];
    end
  end

  p_level_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_push_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (CW'(push_n) <= CW'(DEPTH) - cnt));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/trace_pkt_enc.sv
module trace_pkt_enc
  import trace_pkt_pkg::*;
#(
  parameter int NPORTS     = 32,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      trace_en,
  input  logic                      unit_en,
  input  logic [NPORTS-1:0]         port_en_mask,
  input  logic                      wr_valid,
  input  logic [$clog2(NPORTS)-1:0] wr_port,
  input  logic [1:0]                wr_size,
  input  logic [31:0]               wr_data,
  output logic [NPORTS-1:0]         stim_ready,
  output logic                      out_valid,
  output logic [7:0]                out_data,
  input  logic                      out_ready
);
  localparam int PORT_W = $clog2(NPORTS);
  localparam int CW     = $clog2(FIFO_DEPTH+1);
  localparam int WORST  = 5;

  logic                  gate, wr_live, fits, accept, lost;
  logic                  ovf_pend, ovf_pend_n;
  logic [PKT_MAXB*8-1:0] pkt;
  logic [3:0]            pkt_n;
  logic [CW-1:0]         level, free;

  trace_pkt_build #(.PORT_W(PORT_W)) u_build (
    .port   (wr_port),
    .size   (wr_size),
    .data   (wr_data),
    .ovf_ins(ovf_pend),
    .pkt    (pkt),
    .nbytes (pkt_n)
  );

  trace_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_n    (pkt_n),
    .push_bytes(pkt),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .level     (level)
  );

  assign gate    = trace_en & unit_en;
  assign free    = CW'(FIFO_DEPTH) - level;
  assign wr_live = wr_valid & gate & port_en_mask[wr_port] & (wr_size != SZ_NONE);
  assign fits    = (free >= CW'(pkt_n));
  assign accept  = wr_live & fits;
  assign lost    = wr_live & ~fits;

  always_comb begin
    ovf_pend_n = ovf_pend;
    if (lost)        ovf_pend_n = 1'b1;
    else if (accept) ovf_pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_pend <= 1'b0;
    else        ovf_pend <= ovf_pend_n;
  end

  for (genvar i = 0; i < NPORTS; i++) begin : g_rdy
    assign stim_ready[i] = gate & port_en_mask[i] &
                           (free >= CW'(WORST) + CW'(ovf_pend));
  end

  p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !port_en_mask[wr_port]) |-> !accept);
  p_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(trace_en && unit_en) |-> (!accept && !lost));
  p_lost_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> ovf_pend);
  p_ovf_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ovf_pend) |-> (pkt[7:0] == OVF_MARK));
  p_nosize_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_size == SZ_NONE) |-> (pkt_n == 4'd0 && !accept));
endmodule

// File: tb/trace_pkt_enc_test.sv
module trace_pkt_enc_test;
  localparam int NP = 32;
  localparam int DEPTH = 16;

  logic        clk, rst_n, trace_en, unit_en, wr_valid, out_ready;
  logic [31:0] port_en_mask, wr_data, stim_ready;
  logic [4:0]  wr_port;
  logic [1:0]  wr_size;
  logic        out_valid;
  logic [7:0]  out_data;

  trace_pkt_enc #(.NPORTS(NP), .FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .unit_en(unit_en),
    .port_en_mask(port_en_mask), .wr_valid(wr_valid), .wr_port(wr_port),
    .wr_size(wr_size), .wr_data(wr_data), .stim_ready(stim_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;
  logic [7:0] q[$];
  string      tq[$];
  bit         m_ovf = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int plen(input int sz);
    return (sz == 3) ? 4 : sz;
  endfunction

  // one cycle: called just after a negedge
  task automatic step(input bit v, input int p, input int sz,
                      input logic [31:0] d, input bit rdy);
    bit gate, live, fits, popped, en_rdy;
    int need;
    chk(out_valid == (q.size() != 0), "R8 valid", 32'(out_valid), 32'(q.size() != 0));
    if (q.size() != 0) chk(out_data == q[0], tq[0], 32'(out_data), 32'(q[0]));
    wr_valid  = v;
    wr_port   = 5'(p);
    wr_size   = 2'(sz);
    wr_data   = d;
    out_ready = rdy;
    #1;
    gate = trace_en && unit_en;
    en_rdy = gate && port_en_mask[p] && ((DEPTH - q.size()) >= 5 + int'(m_ovf));
    chk(stim_ready[p] == en_rdy, "R5 ready", 32'(stim_ready[p]), 32'(en_rdy));
    popped = rdy && (q.size() != 0);
    live = v && gate && port_en_mask[p] && (sz != 0);
    need = plen(sz) + 1 + int'(m_ovf);
    fits = (DEPTH - q.size()) >= need;
    if (popped) begin
      void'(q.pop_front());
      void'(tq.pop_front());
    end
    if (live && fits) begin
      if (m_ovf) begin q.push_back(8'h70); tq.push_back("R6 overflow mark"); end
      q.push_back({5'(p), 1'b0, 2'(sz)});
      tq.push_back("R1 header");
      for (int k = 0; k < plen(sz); k++) begin
        q.push_back(d[8*k +: 8]);
        tq.push_back("R2 payload");
      end
      m_ovf = 0;
    end else if (live) begin
      m_ovf = 1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 1);
    chk(q.size() == 0 && !out_valid, "R8 drained", 32'(out_valid), 0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; trace_en = 1; unit_en = 1; port_en_mask = '1;
    wr_valid = 0; wr_port = 0; wr_size = 0; wr_data = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R10 reset", 32'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R10 after reset", 32'(out_valid), 0);
    chk(stim_ready == '1, "R5 reset ready", stim_ready, 32'hffffffff);

    // R1/R2 directed widths and ports
    step(1, 0, 1, 32'h0000_0041, 1);
    step(1, 5, 2, 32'h0000_BEEF, 1);
    step(1, 31, 3, 32'h1234_5678, 1);
    drain();
    // R3 disabled port
    port_en_mask = 32'hFFFF_FFF7;
    step(1, 3, 3, 32'hDEAD_BEEF, 1);
    chk(!out_valid, "R3 disabled port", 32'(out_valid), 0);
    port_en_mask = '1;
    // R4 gating
    trace_en = 0;
    step(1, 1, 1, 32'h11, 1);
    chk(!out_valid, "R4 trace_en low", 32'(out_valid), 0);
    trace_en = 1; unit_en = 0;
    step(1, 1, 1, 32'h22, 1);
    chk(!out_valid, "R4 unit_en low", 32'(out_valid), 0);
    unit_en = 1;
    // R9 size 00
    step(1, 2, 0, 32'h33, 1);
    chk(!out_valid, "R9 size none", 32'(out_valid), 0);
    // R6/R7 overflow: stall output, fill, lose a write, then recover
    for (int i = 0; i < 5; i++) step(1, 2, 3, 32'hA0A0_0000 + 32'(i), 0);
    step(1, 9, 1, 32'h5A, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1);
    step(1, 4, 2, 32'h0000_C3C3, 1);
    drain();
    // R7 exact fit: 15 bytes queued, then byte write (2 bytes) must be lost
    for (int i = 0; i < 3; i++) step(1, 7, 3, 32'h0BAD_F00D, 0);
    step(1, 8, 1, 32'h77, 0);
    step(1, 8, 1, 32'h78, 1);
    drain();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) < 3) port_en_mask = $urandom() | 32'h0000_FFFF;
      if ($urandom_range(0, 99) < 2) trace_en = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 99) < 2) unit_en = ($urandom_range(0, 3) != 0);
      step(($urandom_range(0, 9) < 7), int'($urandom_range(0, 31)),
           int'($urandom_range(0, 3)), $urandom(), ($urandom_range(0, 1) == 1));
    end
    trace_en = 1; unit_en = 1;
    drain();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule